// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block decides where each memory access goes for the system-management memory windows of a host bridge. It holds three configuration registers: an SMRAM control byte, an extended control byte and a 16-bit extended-TSEG-size register. Software writes them through a simple select/data port and reads them back through a combinational read port. For every request the block takes a 32-bit address, an SMM-mode flag and a read/write flag. One clock later it returns a route: DRAM, PCI space (which includes legacy video), or a discard sink. It also returns the address to present to the chosen target.

The block covers three areas. The first is the 128 KB legacy window at 0xA0000. The second is its high alias at 0xFEDA0000, which redirects to DRAM at 0xA0000. The third is the TSEG region, which ends at the top of low memory and extends downward by the selected size. Setting a lock bit freezes the configuration until reset. SMM and non-SMM requests see different maps, and TSEG swallows non-SMM requests.

Top module: `smram_guard`

## Requirements
- R1: After reset the SMRAM control byte (select 0) and the extended control byte (select 1) read 0, rspValid is 0, and the size register (select 2) reads 0xFFFF when EXT_TSEG_MB is nonzero and 0 otherwise. Select 3 reads 0.
- R2: SMRAM control bit layout: bit0 open, bit1 lock, bit2 global enable, bits 7:3 scratch. A write that sets lock clears open in the same write. While lock is set, writes to select 0 change only bits 7:3, and writes to select 1 change nothing, until reset.
- R3: For a non-SMM request to 0xA0000–0xBFFFF, the route is DRAM (code 0) when open=1 and high-enable=0, and PCI (code 1) otherwise. The address is unchanged.
- R4: Extended control bit0 is high-enable. For a non-SMM request to 0xFEDA0000–0xFEDBFFFF with open=1 and high-enable=1, the route is DRAM at address − 0xFED00000. Otherwise the route is PCI with the address unchanged.
- R5: For an SMM request with global enable set, the low window goes to DRAM when high-enable=0, and the high alias goes to DRAM (remapped as in R4) when high-enable=1. In every other case an SMM request gets the non-SMM result.
- R6: Extended control bit3 enables TSEG. Bits 2:1 select the TSEG size: 0 → 1 MB, 1 → 2 MB, 2 → 8 MB, 3 → EXT_TSEG_MB megabytes. With the enable clear, or a size of 0, there is no TSEG.
- R7: Requests in [TOP_LOW − size, TOP_LOW) go to the sink (code 2) when non-SMM and to DRAM when SMM. Other requests below TOP_LOW go to DRAM, and requests at or above TOP_LOW go to PCI.
- R8: Writing 0xFFFF to the size register makes it read EXT_TSEG_MB when EXT_TSEG_MB is nonzero. Any other value written is stored as is.
- R9: cfgError is 1 exactly when EXT_TSEG_MB exceeds EXT_TSEG_MAX.
- R10: rspSinkData is all ones for a read routed to the sink, and 0 for every other response.
- R11: A request accepted on a clock edge produces rspValid and its route on the outputs immediately after that edge. rspValid is low in cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select for writes (0 SMRAM ctl, 1 ext ctl, 2 size) |
| wrData | input | 16 | Write data (bytes use bits 7:0) |
| rdSel | input | 2 | Register select for reads |
| rdData | output | 16 | Read data for rdSel |
| reqValid | input | 1 | Access request present |
| reqAddr | input | 32 | Access address |
| reqSmm | input | 1 | Request issued in SMM |
| reqWrite | input | 1 | Request is a write |
| rspValid | output | 1 | Route result valid |
| rspRoute | output | 2 | 0 DRAM, 1 PCI, 2 sink |
| rspAddr | output | 32 | Address presented to the target |
| rspSinkData | output | 32 | Read data supplied by the sink |
| cfgError | output | 1 | Extended TSEG size parameter out of range |

## Verification
The assertions assume that reset is held for at least one edge before any request or write. They also assume that rspValid and the route are observed only in the cycle after a request. The one-cycle latency check relies on reqValid being a clean level, so the stimulus drives each request for exactly one edge and then drops it. Register writes and requests are kept in separate cycles, so every request sees a settled configuration. Because of this separation, the expected map can be computed from the bench's own copy of the register rules.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    ROUTE_DRAM = 2'd0,
    ROUTE_PCI  = 2'd1,
    ROUTE_SINK = 2'd2
  } route_e;

  localparam logic [31:0] LOW_BASE  = 32'h000A_0000;
  localparam logic [31:0] LOW_LAST  = 32'h000B_FFFF;
  localparam logic [31:0] HIGH_BASE = 32'hFEDA_0000;
  localparam logic [31:0] HIGH_LAST = 32'hFEDB_FFFF;

  // decoded map strobes from control to datapath
  typedef struct packed {
    logic        lowDramNorm;
    logic        highDramNorm;
    logic        lowDramSmm;
    logic        highDramSmm;
    logic        tsegOn;
    logic [31:0] tsegBase;
  } map_t;
endpackage

// File: rtl/smram_ctrl.sv
module smram_ctrl
  import smram_pkg::*;
#(
  parameter logic [31:0] TOP_LOW      = 32'h8000_0000,
  parameter int unsigned EXT_TSEG_MB  = 16,
  parameter int unsigned EXT_TSEG_MAX = 4095
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [15:0] wrData,
  input  logic [1:0]  rdSel,
  output logic [15:0] rdData,
  output map_t        mapCtl,
  output logic        cfgError
);
  localparam logic [15:0] EXT_MB16   = 16'(EXT_TSEG_MB);
  localparam logic [31:0] EXT_BYTES  = 32'(EXT_TSEG_MB) << 20;
  localparam logic [15:0] SIZE_RESET = (EXT_TSEG_MB != 0) ? 16'hFFFF : 16'h0000;

  logic [7:0]  smramReg;
  logic [7:0]  extReg;
  logic [15:0] sizeReg;
  logic        locked;
  logic [31:0] tsegBytes;

  assign locked = smramReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smramReg <= 8'h00;
      extReg   <= 8'h00;
      sizeReg  <= SIZE_RESET;
    end else if (wrEn) begin
      case (wrSel)
        2'd0: begin
          if (locked) smramReg[7:3] <= wrData[7:3];
          else smramReg <= {wrData[7:2], wrData[1], wrData[0] & ~wrData[1]};
        end
        2'd1: if (!locked) extReg <= wrData[7:0];
        2'd2: sizeReg <= (wrData == 16'hFFFF && EXT_TSEG_MB != 0) ? EXT_MB16 : wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (extReg[2:1])
      2'd0:    tsegBytes = 32'h0010_0000;
      2'd1:    tsegBytes = 32'h0020_0000;
      2'd2:    tsegBytes = 32'h0080_0000;
      default: tsegBytes = EXT_BYTES;
    endcase
  end

  always_comb begin
    mapCtl.lowDramNorm  = smramReg[0] & ~extReg[0];
    mapCtl.highDramNorm = smramReg[0] &  extReg[0];
    mapCtl.lowDramSmm   = smramReg[2] & ~extReg[0];
    mapCtl.highDramSmm  = smramReg[2] &  extReg[0];
    mapCtl.tsegOn       = extReg[3] && (tsegBytes != 32'd0);
    mapCtl.tsegBase     = TOP_LOW - tsegBytes;
  end

  always_comb begin
    case (rdSel)
      2'd0:    rdData = {8'h00, smramReg};
      2'd1:    rdData = {8'h00, extReg};
      2'd2:    rdData = sizeReg;
      default: rdData = 16'h0000;
    endcase
  end

  assign cfgError = (EXT_TSEG_MB > EXT_TSEG_MAX);

  // R2: once locked, the map-relevant bits hold
  p_lock_freeze_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(smramReg[1]) |-> (smramReg[2:0] == $past(smramReg[2:0]) && extReg == $past(extReg)));

  // R2: lock and open never both set
  p_lock_closed_r2: assert property (@(posedge clk) disable iff (!rstN)
    smramReg[1] |-> !smramReg[0]);

  // R8: query write returns configured size
  p_query_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2 && wrData == 16'hFFFF && EXT_TSEG_MB != 0) |=> (sizeReg == EXT_MB16));
endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
#(
  parameter logic [31:0] TOP_LOW = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  map_t        mapCtl,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        reqSmm,
  input  logic        reqWrite,
  output logic        rspValid,
  output route_e      rspRoute,
  output logic [31:0] rspAddr,
  output logic [31:0] rspSinkData
);
  logic        inLow, inHigh, inTseg;
  route_e      nextRoute;
  logic [31:0] nextAddr;

  assign inLow  = (reqAddr >= LOW_BASE)  && (reqAddr <= LOW_LAST);
  assign inHigh = (reqAddr >= HIGH_BASE) && (reqAddr <= HIGH_LAST);
  assign inTseg = mapCtl.tsegOn && (reqAddr >= mapCtl.tsegBase) && (reqAddr < TOP_LOW);

  always_comb begin
    nextAddr = reqAddr;
    if (inLow) begin
      nextRoute = ((reqSmm && mapCtl.lowDramSmm) || mapCtl.lowDramNorm) ? ROUTE_DRAM : ROUTE_PCI;
    end else if (inHigh) begin
      if ((reqSmm && mapCtl.highDramSmm) || mapCtl.highDramNorm) begin
        nextRoute = ROUTE_DRAM;
        nextAddr  = reqAddr - HIGH_BASE + LOW_BASE;
      end else begin
        nextRoute = ROUTE_PCI;
      end
    end else if (inTseg) begin
      nextRoute = reqSmm ? ROUTE_DRAM : ROUTE_SINK;
    end else if (reqAddr < TOP_LOW) begin
      nextRoute = ROUTE_DRAM;
    end else begin
      nextRoute = ROUTE_PCI;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspRoute    <= ROUTE_DRAM;
      rspAddr     <= 32'd0;
      rspSinkData <= 32'd0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspRoute    <= nextRoute;
        rspAddr     <= nextAddr;
        rspSinkData <= (nextRoute == ROUTE_SINK && !reqWrite) ? 32'hFFFF_FFFF : 32'd0;
      end
    end
  end

  // R11: one-clock latency
  p_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R7: only non-SMM traffic reaches the sink
  p_sink_smm_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspRoute == ROUTE_SINK) |-> !$past(reqSmm));

  // R10: fill data only for the sink
  p_fill_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspRoute != ROUTE_SINK) |-> (rspSinkData == 32'd0));

  // R4: alias hits land in the legacy window
  p_alias_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspRoute == ROUTE_DRAM && $past(reqAddr) >= HIGH_BASE && $past(reqAddr) <= HIGH_LAST)
      |-> (rspAddr >= LOW_BASE && rspAddr <= LOW_LAST));
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smram_pkg::*;
#(
  parameter logic [31:0] TOP_LOW      = 32'h8000_0000,
  parameter int unsigned EXT_TSEG_MB  = 16,
  parameter int unsigned EXT_TSEG_MAX = 4095
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [15:0] wrData,
  input  logic [1:0]  rdSel,
  output logic [15:0] rdData,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        reqSmm,
  input  logic        reqWrite,
  output logic        rspValid,
  output logic [1:0]  rspRoute,
  output logic [31:0] rspAddr,
  output logic [31:0] rspSinkData,
  output logic        cfgError
);
  map_t   mapCtl;
  route_e routeInt;

  smram_ctrl #(.TOP_LOW(TOP_LOW), .EXT_TSEG_MB(EXT_TSEG_MB), .EXT_TSEG_MAX(EXT_TSEG_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .mapCtl(mapCtl), .cfgError(cfgError)
  );

  smram_route #(.TOP_LOW(TOP_LOW)) uRoute (
    .clk(clk), .rstN(rstN), .mapCtl(mapCtl), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSmm(reqSmm), .reqWrite(reqWrite), .rspValid(rspValid), .rspRoute(routeInt),
    .rspAddr(rspAddr), .rspSinkData(rspSinkData)
  );

  assign rspRoute = routeInt;
endmodule

// File: tb/tb_smram_guard.sv
`timescale 1ns/1ps
module tb_smram_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TOPL = 32'h8000_0000;
  localparam int EXTMB = 16;

  logic clk = 0, rstN = 0;
  logic wrEn = 0; logic [1:0] wrSel = 0; logic [15:0] wrData = 0;
  logic [1:0] rdSel = 0; logic [15:0] rdData;
  logic reqValid = 0; logic [31:0] reqAddr = 0; logic reqSmm = 0, reqWrite = 0;
  logic rspValid; logic [1:0] rspRoute; logic [31:0] rspAddr, rspSinkData;
  logic cfgError;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the registers
  bit mOpen, mLock, mGlob, mHigh, mTen;
  logic [4:0] mScr; logic [3:0] mExtHi; logic [1:0] mCode;

  logic [1:0]  qRoute[$];
  logic [31:0] qAddr[$];
  logic [31:0] qFill[$];
  string       qTag[$];

  smram_guard #(.TOP_LOW(TOPL), .EXT_TSEG_MB(EXTMB), .EXT_TSEG_MAX(4095)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSmm(reqSmm), .reqWrite(reqWrite), .rspValid(rspValid), .rspRoute(rspRoute),
    .rspAddr(rspAddr), .rspSinkData(rspSinkData), .cfgError(cfgError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk); #1;
    wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk); #1;
    wrEn = 0;
    case (sel)
      2'd0: if (mLock) mScr = d[7:3];
            else begin mScr = d[7:3]; mGlob = d[2]; mLock = d[1]; mOpen = d[0] & ~d[1]; end
      2'd1: if (!mLock) begin mExtHi = d[7:4]; mTen = d[3]; mCode = d[2:1]; mHigh = d[0]; end
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] sel, logic [15:0] exp, string tag);
    @(negedge clk); #1;
    rdSel = sel; #1;
    check(tag, {16'h0, rdData}, {16'h0, exp});
  endtask

  function automatic logic [31:0] tsegSize();
    if (!mTen) return 32'd0;
    case (mCode)
      2'd0: return 32'h0010_0000;
      2'd1: return 32'h0020_0000;
      2'd2: return 32'h0080_0000;
      default: return 32'(EXTMB) << 20;
    endcase
  endfunction

  task automatic acc(logic [31:0] a, bit smm, bit w, string tag);
    logic [1:0] r; logic [31:0] ea; logic [31:0] sz;
    ea = a; sz = tsegSize();
    if (a >= 32'h000A_0000 && a <= 32'h000B_FFFF) begin
      r = ((smm && mGlob && !mHigh) || (mOpen && !mHigh)) ? 2'd0 : 2'd1;
    end else if (a >= 32'hFEDA_0000 && a <= 32'hFEDB_FFFF) begin
      if ((smm && mGlob && mHigh) || (mOpen && mHigh)) begin r = 2'd0; ea = a - 32'hFED0_0000; end
      else r = 2'd1;
    end else if (sz != 0 && a >= TOPL - sz && a < TOPL) begin
      r = smm ? 2'd0 : 2'd2;
    end else begin
      r = (a < TOPL) ? 2'd0 : 2'd1;
    end
    @(negedge clk); #1;
    reqValid = 1; reqAddr = a; reqSmm = smm; reqWrite = w;
    qRoute.push_back(r); qAddr.push_back(ea);
    qFill.push_back((r == 2'd2 && !w) ? 32'hFFFF_FFFF : 32'h0);
    qTag.push_back(tag);
    @(negedge clk); #1;
    reqValid = 0;
  endtask

  // monitor: each queued item must answer on the next falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (qRoute.size() != 0) begin
        string t;
        t = qTag.pop_front();
        check({t, " R11 valid"}, {31'h0, rspValid}, 32'h1);
        check({t, " route"}, {30'h0, rspRoute}, {30'h0, qRoute.pop_front()});
        check({t, " addr"}, rspAddr, qAddr.pop_front());
        check({t, " R10 fill"}, rspSinkData, qFill.pop_front());
      end else if (rspValid) begin
        check("R11 spurious rspValid", 32'h1, 32'h0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check("watchdog", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    // R1 reset state
    check("R1 rspValid", {31'h0, rspValid}, 32'h0);
    rd(2'd0, 16'h0000, "R1 smram ctl");
    rd(2'd1, 16'h0000, "R1 ext ctl");
    rd(2'd2, 16'hFFFF, "R1 size query");
    rd(2'd3, 16'h0000, "R1 unused select");
    check("R9 cfgError", {31'h0, cfgError}, 32'h0);

    // default map
    acc(32'h000A_1000, 0, 0, "R3 closed low");
    acc(32'hFEDA_0040, 0, 0, "R4 closed alias");
    acc(32'h000B_FFFF, 1, 0, "R5 smm global off");
    acc(32'h0000_1000, 0, 0, "R7 low dram");
    acc(32'h9000_0000, 0, 1, "R7 above top");
    acc(32'h7FF8_0000, 0, 0, "R6 tseg disabled");

    wr(2'd0, 16'h0001);
    acc(32'h000A_0000, 0, 0, "R3 open low");
    wr(2'd1, 16'h0001);
    acc(32'h000A_0000, 0, 0, "R3 open high-enable");
    acc(32'hFEDA_1234, 0, 0, "R4 open alias");
    acc(32'hFEDC_0000, 0, 0, "R4 past alias");
    wr(2'd0, 16'h0004);
    acc(32'hFEDB_FFF0, 1, 0, "R5 smm alias");
    acc(32'hFEDB_FFF0, 0, 0, "R4 non-smm alias closed");
    acc(32'h000A_8000, 1, 0, "R5 smm low with high");
    wr(2'd1, 16'h0000);
    acc(32'h000A_8000, 1, 0, "R5 smm low");
    acc(32'h000A_8000, 0, 0, "R3 non-smm global only");

    // TSEG sizes
    wr(2'd1, 16'h0008);
    acc(32'h7FF0_0000, 0, 0, "R7 tseg 1M read");
    acc(32'h7FFF_FFFC, 0, 1, "R7 tseg 1M write");
    acc(32'h7FF0_0000, 1, 0, "R7 tseg smm");
    acc(32'h7FEF_FFFF, 0, 0, "R6 below 1M");
    wr(2'd1, 16'h000A);
    acc(32'h7FE0_0000, 0, 0, "R6 tseg 2M");
    acc(32'h7FDF_FFFF, 0, 0, "R6 below 2M");
    wr(2'd1, 16'h000C);
    acc(32'h7F80_0000, 0, 0, "R6 tseg 8M");
    wr(2'd1, 16'h000E);
    acc(32'h7F00_0000, 0, 0, "R6 tseg ext");
    acc(32'h7EFF_FFFF, 0, 0, "R6 below ext");

    // size register
    wr(2'd2, 16'h0123);
    rd(2'd2, 16'h0123, "R8 plain store");
    wr(2'd2, 16'hFFFF);
    rd(2'd2, 16'(EXTMB), "R8 query");

    // lock
    wr(2'd0, 16'h0007);
    rd(2'd0, 16'h0006, "R2 lock clears open");
    acc(32'h000A_0000, 0, 0, "R2 locked low closed");
    wr(2'd0, 16'h00F9);
    rd(2'd0, 16'h00FE, "R2 only scratch writable");
    wr(2'd1, 16'h0000);
    rd(2'd1, 16'h000E, "R2 ext frozen");
    acc(32'h7F00_0000, 0, 0, "R2 tseg kept");

    repeat (3) @(negedge clk);
    check("R11 queue drained", qRoute.size(), 0);
    finishRun();
  end
endmodule